// File: doc/BRIEF.md
# Floating-Point Control and Status Register with Remapped Views

This block holds the 32-bit floating-point control and status word and gives software five ways to reach it through one indexed access port. Index 31 is the whole word. Index 25 gives only the eight condition codes, packed into one byte. Index 26 gives the cause and sticky-flag fields. Index 28 gives the rounding mode, the trap enables and the flush-to-zero bit, moved to a new position. Index 0 is a read-only implementation word. Every read is sign-extended from bit 31 to the full register width.

The arithmetic units report the outcome of each operation on a status input. The block reloads the cause field from that report. It then tests for a trap and only after that merges the new causes into the sticky flags. A one-cycle exception request goes out whenever a trap test finds an enabled cause or an unimplemented-operation cause. The rounding mode, the flush-to-zero bit and the condition codes are driven straight out to the datapath.

Top module: `fpcsr_views`

## Requirements
- R1: After reset the control word is zero, the exception request is low, all exported fields are zero, and index 31 reads zero.
- R2: The word layout is as follows. Rounding mode is [1:0]. Sticky flags are [6:2], enables are [11:7] and causes are [16:12], each field ordered inexact, underflow, overflow, divide-by-zero, invalid from its low bit up. The unimplemented-operation cause is bit 17. Bits [22:18] are reserved. Condition code 0 is bit 23, flush-to-zero is bit 24, and condition codes 1 to 7 are [31:25]. A write to index 31 loads the low 32 bits of the write data with the reserved bits cleared. A read returns the word with the reserved bits zero, sign-extended.
- R3: A read of index 25 returns condition code 0 in bit 0 and codes 1 to 7 in bits [7:1], with all other bits zero. A write to index 25 takes those bits back to their separated positions and changes nothing else.
- R4: Index 26 reads only the cause bits [17:12] and flag bits [6:2], at their word positions. A write to index 26 replaces only those bits.
- R5: Index 28 reads the enables and rounding mode at their word positions and the flush-to-zero bit at bit 2.
- R6: A write to index 28 sets flush-to-zero from data bit 2 and the enables and rounding mode from their word positions. It keeps the condition codes, causes and flags.
- R7: Index 0 reads the parameter IMPL_ID, sign-extended, and a write to it is ignored.
- R8: Any index other than 0, 25, 26, 28 and 31 reads zero, and a write to it changes nothing.
- R9: In the cycle after a write to index 26, 28 or 31, or after a status report, the exception request equals (cause[4:0] AND enables) nonzero OR unimplemented-operation cause set. The test uses the updated word.
- R10: A status report (st_valid, with st_flags bit 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid) replaces the whole cause field with the reported bits and clears the unimplemented-operation cause.
- R11: A status report ORs its bits into the sticky flags. Flags are cleared only by a write to index 26 or 31.
- R12: round_mode, flush_zero and cond_codes (code 0 in bit 0) always reflect the current word.
- R13: When a write and a status report fall in the same cycle, the write is applied first and the status report on top of it.
- R14: The exception request is low in any cycle that does not follow a write to index 26, 28 or 31 or a status report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_idx | input | IDX_W | Register index for read and write |
| wr_en | input | 1 | Write strobe for the indexed view |
| wr_data | input | XLEN | Write data; the low 32 bits are used |
| rd_data | output | XLEN | Indexed view of the current word, sign-extended |
| st_valid | input | 1 | Status report strobe from the arithmetic units |
| st_flags | input | 5 | Reported exceptions: inexact, underflow, overflow, divide-by-zero, invalid |
| fpe_req | output | 1 | One-cycle floating-point exception request |
| round_mode | output | 2 | Current rounding mode |
| flush_zero | output | 1 | Current flush-to-zero bit |
| cond_codes | output | 8 | Condition codes, code 0 in bit 0 |

## Verification
Read data is combinational from the stored word. A write or status report strobed at one edge therefore shows on rd_data and on the exported fields from that edge on. The exception request is registered at that same edge, so it is due one cycle after the strobe and drops at the following edge. The bench drives strobes on the falling edge and samples fpe_req on the next falling edge. It then moves the index and samples rd_data a nanosecond later, with no rising edge in between. A separate idle cycle confirms that the request is gone.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

   localparam int CSR_W      = 32;
   localparam int RM_LO      = 0;
   localparam int RM_W       = 2;
   localparam int XF_W       = 5;
   localparam int FLG_LO     = 2;
   localparam int EN_LO      = 7;
   localparam int CAU_LO     = 12;
   localparam int CAU_W      = XF_W + 1;
   localparam int UNIMP_BIT  = CAU_LO + XF_W;
   localparam int FCC_N      = 8;
   localparam int FCC0_BIT   = 23;
   localparam int FS_BIT     = 24;
   localparam int FCCH_LO    = 25;
   localparam int VIEW_FS    = 2;

   localparam logic [CSR_W-1:0] RSV_MASK  = 32'h007C_0000;
   localparam logic [CSR_W-1:0] XCPT_MASK = 32'h0003_F07C;
   localparam logic [CSR_W-1:0] CTRL_MASK = 32'h0000_0F83;

   localparam int unsigned IX_IMPL = 0;
   localparam int unsigned IX_FCC  = 25;
   localparam int unsigned IX_XCPT = 26;
   localparam int unsigned IX_CTRL = 28;
   localparam int unsigned IX_FULL = 31;

   typedef enum logic [2:0] {
      VW_NONE,
      VW_IMPL,
      VW_FCC,
      VW_XCPT,
      VW_CTRL,
      VW_FULL
   } view_e;

endpackage

// File: rtl/fpcsr_decode.sv
module fpcsr_decode
   import fpcsr_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0] idx,
   output view_e            view
);
   localparam logic [IDX_W-1:0] K_IMPL = IDX_W'(IX_IMPL);
   localparam logic [IDX_W-1:0] K_FCC  = IDX_W'(IX_FCC);
   localparam logic [IDX_W-1:0] K_XCPT = IDX_W'(IX_XCPT);
   localparam logic [IDX_W-1:0] K_CTRL = IDX_W'(IX_CTRL);
   localparam logic [IDX_W-1:0] K_FULL = IDX_W'(IX_FULL);

   always_comb begin
      if      (idx == K_IMPL) view = VW_IMPL;
      else if (idx == K_FCC)  view = VW_FCC;
      else if (idx == K_XCPT) view = VW_XCPT;
      else if (idx == K_CTRL) view = VW_CTRL;
      else if (idx == K_FULL) view = VW_FULL;
      else                    view = VW_NONE;
   end
endmodule

// File: rtl/fpcsr_merge.sv
module fpcsr_merge
   import fpcsr_pkg::*;
(
   input  logic [CSR_W-1:0] cur,
   input  view_e            view,
   input  logic             wr_en,
   input  logic [CSR_W-1:0] wdata,
   input  logic             st_valid,
   input  logic [XF_W-1:0]  st_flags,
   output logic [CSR_W-1:0] nxt,
   output logic             check_ev,
   output logic             trap
);
   logic [CSR_W-1:0] after_wr;

   always_comb begin
      after_wr = cur;
      if (wr_en) begin
         unique case (view)
            VW_FCC: begin
               after_wr[FCC0_BIT]               = wdata[0];
               after_wr[FCCH_LO +: FCC_N-1]     = wdata[FCC_N-1:1];
            end
            VW_XCPT: begin
               after_wr = (cur & ~XCPT_MASK) | (wdata & XCPT_MASK);
            end
            VW_CTRL: begin
               after_wr[FS_BIT]          = wdata[VIEW_FS];
               after_wr[EN_LO +: XF_W]   = wdata[EN_LO +: XF_W];
               after_wr[RM_LO +: RM_W]   = wdata[RM_LO +: RM_W];
            end
            VW_FULL: after_wr = wdata & ~RSV_MASK;
            default: ;
         endcase
      end
   end

   always_comb begin
      nxt = after_wr;
      if (st_valid)
         nxt[CAU_LO +: CAU_W] = {1'b0, st_flags};
      // trap test sees the new causes before the flags absorb them
      trap = (|(nxt[CAU_LO +: XF_W] & nxt[EN_LO +: XF_W])) | nxt[UNIMP_BIT];
      if (st_valid)
         nxt[FLG_LO +: XF_W] = nxt[FLG_LO +: XF_W] | st_flags;
      check_ev = st_valid |
                 (wr_en & ((view == VW_XCPT) | (view == VW_CTRL) | (view == VW_FULL)));
   end
endmodule

// File: rtl/fpcsr_rdmux.sv
module fpcsr_rdmux
   import fpcsr_pkg::*;
#(
   parameter logic [31:0] IMPL_ID = 32'h0000_3A10
) (
   input  view_e            view,
   input  logic [CSR_W-1:0] cur,
   output logic [CSR_W-1:0] rd32
);
   always_comb begin
      unique case (view)
         VW_IMPL: rd32 = IMPL_ID;
         VW_FCC:  rd32 = {{(CSR_W-FCC_N){1'b0}}, cur[FCCH_LO +: FCC_N-1], cur[FCC0_BIT]};
         VW_XCPT: rd32 = cur & XCPT_MASK;
         VW_CTRL: rd32 = (cur & CTRL_MASK) | (CSR_W'(cur[FS_BIT]) << VIEW_FS);
         VW_FULL: rd32 = cur & ~RSV_MASK;
         default: rd32 = '0;
      endcase
   end
endmodule

// File: rtl/fpcsr_views.sv
module fpcsr_views
   import fpcsr_pkg::*;
#(
   parameter int          XLEN    = 64,
   parameter int          IDX_W   = 5,
   parameter logic [31:0] IMPL_ID = 32'h0000_3A10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic             wr_en,
   input  logic [XLEN-1:0]  wr_data,
   output logic [XLEN-1:0]  rd_data,
   input  logic             st_valid,
   input  logic [XF_W-1:0]  st_flags,
   output logic             fpe_req,
   output logic [RM_W-1:0]  round_mode,
   output logic             flush_zero,
   output logic [FCC_N-1:0] cond_codes
);
   localparam int EXT_W = XLEN - CSR_W;

   generate
      if (XLEN < CSR_W) begin : g_bad_xlen
         $error("fpcsr_views: XLEN must be at least 32");
      end
      if (IDX_W < 5) begin : g_bad_idx
         $error("fpcsr_views: IDX_W must be at least 5");
      end
   endgenerate

   view_e            view;
   logic [CSR_W-1:0] fcsr_q;
   logic [CSR_W-1:0] fcsr_nxt;
   logic [CSR_W-1:0] rd32;
   logic             check_ev;
   logic             trap;
   logic             fpe_q;

   fpcsr_decode #(.IDX_W(IDX_W)) u_dec (
      .idx  (acc_idx),
      .view (view)
   );

   fpcsr_merge u_merge (
      .cur      (fcsr_q),
      .view     (view),
      .wr_en    (wr_en),
      .wdata    (wr_data[CSR_W-1:0]),
      .st_valid (st_valid),
      .st_flags (st_flags),
      .nxt      (fcsr_nxt),
      .check_ev (check_ev),
      .trap     (trap)
   );

   fpcsr_rdmux #(.IMPL_ID(IMPL_ID)) u_rd (
      .view (view),
      .cur  (fcsr_q),
      .rd32 (rd32)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcsr_q <= '0;
         fpe_q  <= 1'b0;
      end else begin
         fcsr_q <= fcsr_nxt;
         fpe_q  <= check_ev & trap;
      end
   end

   generate
      if (EXT_W == 0) begin : g_no_ext
         assign rd_data = rd32;
      end else begin : g_sext
         assign rd_data = {{EXT_W{rd32[CSR_W-1]}}, rd32};
      end
   endgenerate

   assign fpe_req    = fpe_q;
   assign round_mode = fcsr_q[RM_LO +: RM_W];
   assign flush_zero = fcsr_q[FS_BIT];
   assign cond_codes = {fcsr_q[FCCH_LO +: FCC_N-1], fcsr_q[FCC0_BIT]};

endmodule

// File: rtl/fpcsr_views_chk.sv
module fpcsr_views_chk #(
   parameter int IDX_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] acc_idx,
   input logic             wr_en,
   input logic             st_valid,
   input logic [4:0]       st_flags,
   input logic             fpe_req,
   input logic [31:0]      fcsr
);
   logic hit_fcc, hit_xcpt, hit_ctrl, hit_full, chk_ev;
   assign hit_fcc  = (acc_idx == IDX_W'(25));
   assign hit_xcpt = (acc_idx == IDX_W'(26));
   assign hit_ctrl = (acc_idx == IDX_W'(28));
   assign hit_full = (acc_idx == IDX_W'(31));
   assign chk_ev   = st_valid | (wr_en & (hit_xcpt | hit_ctrl | hit_full));

   a_r9_trap_follows_check: assert property (@(posedge clk) disable iff (!rst_n)
      chk_ev |=> (fpe_req == ((|(fcsr[16:12] & fcsr[11:7])) || fcsr[17])));

   a_r14_quiet_without_check: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_ev |=> !fpe_req);

   a_r2_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
      fcsr[22:18] == 5'd0);

   a_r10_cause_reload: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |=> (fcsr[17:12] == {1'b0, $past(st_flags)}));

   a_r11_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (hit_xcpt || hit_full)) |=>
         ((fcsr[6:2] & $past(fcsr[6:2])) == $past(fcsr[6:2])));

   a_r6_ctrl_keeps_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_ctrl && !st_valid) |=>
         $stable({fcsr[31:25], fcsr[23], fcsr[17:12], fcsr[6:2]}));

   a_r8_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !st_valid && !(hit_fcc || hit_xcpt || hit_ctrl || hit_full)) |=>
         $stable(fcsr));

endmodule

bind fpcsr_views fpcsr_views_chk #(.IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .acc_idx  (acc_idx),
   .wr_en    (wr_en),
   .st_valid (st_valid),
   .st_flags (st_flags),
   .fpe_req  (fpe_req),
   .fcsr     (fcsr_q)
);

// File: tb/fpcsr_views_tb.sv
module fpcsr_views_tb;
   localparam logic [31:0] IMPL = 32'h0000_3A10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  acc_idx = '0;
   logic        wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic [63:0] rd_data;
   logic        st_valid = 1'b0;
   logic [4:0]  st_flags = '0;
   logic        fpe_req;
   logic [1:0]  round_mode;
   logic        flush_zero;
   logic [7:0]  cond_codes;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fpcsr_views #(.XLEN(64), .IDX_W(5), .IMPL_ID(IMPL)) u_dut (
      .clk(clk), .rst_n(rst_n), .acc_idx(acc_idx), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .st_valid(st_valid),
      .st_flags(st_flags), .fpe_req(fpe_req), .round_mode(round_mode),
      .flush_zero(flush_zero), .cond_codes(cond_codes)
   );

   typedef struct packed {
      logic [4:0]  widx;
      logic [31:0] wdat;
      logic [4:0]  ridx;
      logic [63:0] rexp;
      logic        fexp;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{5'd31, 32'hFFFF_FFFF, 5'd31, 64'hFFFF_FFFF_FF83_FFFF, 1'b1}, // R2 R9
      '{5'd31, 32'h0000_0000, 5'd31, 64'h0,                   1'b0}, // R2
      '{5'd25, 32'h0000_00A5, 5'd25, 64'hA5,                  1'b0}, // R3
      '{5'd5,  32'hFFFF_FFFF, 5'd31, 64'hFFFF_FFFF_A480_0000, 1'b0}, // R8 R3
      '{5'd26, 32'hFFFF_FFFF, 5'd26, 64'h0003_F07C,           1'b1}, // R4 R9
      '{5'd28, 32'h0000_0F87, 5'd28, 64'h0F87,                1'b1}, // R5 R6
      '{5'd0,  32'hFFFF_FFFF, 5'd31, 64'hFFFF_FFFF_A583_FFFF, 1'b0}, // R7 R6
      '{5'd26, 32'h0000_2000, 5'd26, 64'h2000,                1'b1}, // R4 R9
      '{5'd28, 32'h0000_0001, 5'd28, 64'h1,                   1'b0}, // R6 R9
      '{5'd3,  32'h0000_0000, 5'd25, 64'hA5,                  1'b0}, // R3 R8
      '{5'd31, 32'h0022_0000, 5'd31, 64'h2_0000,              1'b1}  // R9 unimpl
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // one strobe cycle driven on the falling edge; returns on the next falling edge
   task automatic step(input logic w, input logic [4:0] i, input logic [31:0] d,
                       input logic s, input logic [4:0] f);
      @(negedge clk);
      acc_idx  = i;
      wr_en    = w;
      wr_data  = {32'h0, d};
      st_valid = s;
      st_flags = f;
      @(negedge clk);
      wr_en    = 1'b0;
      st_valid = 1'b0;
      st_flags = '0;
   endtask

   task automatic rd(input logic [4:0] i, output logic [63:0] v);
      acc_idx = i;
      #1;
      v = rd_data;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R1 act=hung exp=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(5'd31, v);            chk("R1 full view", v, 64'h0);
      chk("R1 fpe_req", {63'h0, fpe_req}, 64'h0);
      chk("R1 exports", {53'h0, round_mode, flush_zero, cond_codes}, 64'h0);
      rd(5'd0, v);             chk("R7 impl read", v, {32'h0, IMPL});

      for (int k = 0; k < NV; k++) begin
         step(1'b1, VECS[k].widx, VECS[k].wdat, 1'b0, 5'h0);
         chk($sformatf("R9 fpe vec%0d", k), {63'h0, fpe_req}, {63'h0, VECS[k].fexp});
         rd(VECS[k].ridx, v);
         chk($sformatf("R2-view vec%0d", k), v, VECS[k].rexp);
      end

      // enable overflow only, word now 0x200
      step(1'b1, 5'd31, 32'h0000_0200, 1'b0, 5'h0);
      chk("R9 no cause no trap", {63'h0, fpe_req}, 64'h0);

      step(1'b0, 5'd0, 32'h0, 1'b1, 5'b00001);
      chk("R10 inexact not enabled", {63'h0, fpe_req}, 64'h0);
      rd(5'd26, v);            chk("R10 inexact cause/flag", v, 64'h1004);

      step(1'b0, 5'd0, 32'h0, 1'b1, 5'b00100);
      chk("R9 overflow trap on status", {63'h0, fpe_req}, 64'h1);
      rd(5'd26, v);            chk("R11 sticky flags", v, 64'h4014);

      @(negedge clk);
      chk("R14 request drops", {63'h0, fpe_req}, 64'h0);

      step(1'b0, 5'd0, 32'h0, 1'b1, 5'b11000);
      chk("R10 invalid+dz no trap", {63'h0, fpe_req}, 64'h0);
      rd(5'd26, v);            chk("R10 invalid+dz cause", v, 64'h1_8074);

      // R13 write with unimpl cause and status in the same cycle
      step(1'b1, 5'd26, 32'h0002_0000, 1'b1, 5'b00010);
      chk("R13 status over write fpe", {63'h0, fpe_req}, 64'h0);
      rd(5'd26, v);            chk("R13 status over write", v, 64'h2008);
      rd(5'd28, v);            chk("R6 enables kept", v, 64'h200);

      rd(5'd7, v);             chk("R8 undefined read", v, 64'h0);
      rd(5'd30, v);            chk("R8 undefined read 30", v, 64'h0);

      step(1'b1, 5'd31, 32'h8180_0002, 1'b0, 5'h0);
      chk("R12 round_mode", {62'h0, round_mode}, 64'h2);
      chk("R12 flush_zero", {63'h0, flush_zero}, 64'h1);
      chk("R12 cond_codes", {56'h0, cond_codes}, 64'h81);
      rd(5'd25, v);            chk("R3 packed codes", v, 64'h81);
      rd(5'd28, v);            chk("R5 fs at bit 2", v, 64'h6);

      // R1 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      rd(5'd31, v);            chk("R1 full view after reset", v, 64'h0);
      chk("R1 exports after reset", {53'h0, round_mode, flush_zero, cond_codes}, 64'h0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule